// File: doc/BRIEF.md
# Row Retirement Column Sweep Sequencer

When a memory error is reported at a DRAM location, every physical page that shares the failing row should be taken out of service. This block receives one captured error address and runs through all column values of that row, from 0 up to 31. For each value it rebuilds the error address with the new column and sends it to an external address translator. It then checks the resulting page with an external page status store. It issues a retire command for each page that translated without error, is a valid online page, and is not already marked poisoned.

The translator and the page store sit behind request/response handshake ports. The retire command leaves on a valid/ready handshake, and the sequencer waits for each command to be taken. The walk runs only when the mode input selects the heterogeneous fabric revision. In any other mode, a start request finishes at once and causes no traffic.

Top module: `row_sweep_retire`

## Requirements
- R1: After reset, xlReqValid, pgReqValid, retValid, busy and donePulse are all low.
- R2: A start request while idle with heteroMode low gives donePulse high on the next cycle, leaves busy low, and issues no translation, page or retire request.
- R3: A start request while idle with heteroMode high issues exactly 32 translation requests, one per column, in ascending order from 0 to 31. Each request address equals the captured errAddr with bits 5:1 replaced by the column number; every other bit is unchanged.
- R4: A translation response with xlRspErr high causes no page request and no retire for that column.
- R5: After an error-free translation, one page request is issued whose pgReqPfn equals the returned physical address shifted right by 12.
- R6: A page response with pgRspOnline low causes no retire for that column.
- R7: A page response with pgRspPoisoned high causes no retire for that column.
- R8: A page that is online and not poisoned produces exactly one retire command whose retPfn equals that page frame number. retValid and retPfn hold steady until retReady is seen.
- R9: At most one of xlReqValid, pgReqValid and retValid is high at a time. A raised request holds its valid and payload until its ready is seen.
- R10: After the last column's step completes, donePulse is high for exactly one cycle, and busy is low in that same cycle.
- R11: startReq and errAddr are ignored while busy. The sweep continues on the address captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse; the address is captured when idle |
| errAddr | input | ADDR_W | Failing DRAM error address |
| heteroMode | input | 1 | High selects the heterogeneous fabric revision (sweep enabled) |
| xlReqValid | output | 1 | Translation request valid |
| xlReqReady | input | 1 | Translator accepts the request |
| xlReqAddr | output | ADDR_W | Error address with the swept column inserted |
| xlRspValid | input | 1 | Translation response valid |
| xlRspErr | input | 1 | Translation failed |
| xlRspPhys | input | PA_W | Translated physical address |
| pgReqValid | output | 1 | Page lookup request valid |
| pgReqReady | input | 1 | Page store accepts the lookup |
| pgReqPfn | output | PA_W-PAGE_SHIFT | Page frame number being looked up |
| pgRspValid | input | 1 | Page lookup response valid |
| pgRspOnline | input | 1 | A valid online page exists |
| pgRspPoisoned | input | 1 | The page is already poisoned |
| retValid | output | 1 | Retire command valid |
| retReady | input | 1 | Retire command accepted |
| retPfn | output | PA_W-PAGE_SHIFT | Page frame number to retire |
| busy | output | 1 | Sweep in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the translator and the page store answer each accepted request with exactly one response, and never send a response that was not asked for. The stall and hold properties depend on these well-behaved partners. The bench models both partners as single-outstanding responders that raise ready and response valid only after seeing a request. They insert varying stall and latency cycles. Start pulses are driven only on cycles the bench controls, including deliberate start pulses while a sweep is running.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XLATE_REQ,
    S_XLATE_WAIT,
    S_PAGE_REQ,
    S_PAGE_WAIT,
    S_RETIRE,
    S_NEXT
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // load error address, clear column counter
    logic advance;    // step to next column
    logic latchPhys;  // hold the translated physical address
  } dpStrobe_t;

endpackage

// File: rtl/rsr_datapath.sv
module rsr_datapath
  import rsr_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int COL_LSB    = 1,
  parameter int COL_W      = 5,
  parameter int PA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]          errAddr,
  input  logic [PA_W-1:0]            xlRspPhys,
  output logic [ADDR_W-1:0]          sweptAddr,
  output logic [PA_W-PAGE_SHIFT-1:0] pfn,
  output logic                       lastCol
);

  localparam int COL_MSB = COL_LSB + COL_W - 1;

  logic [ADDR_W-1:0] baseAddr;
  logic [COL_W-1:0]  colCnt;
  logic [PA_W-1:0]   physQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      colCnt   <= '0;
    end else if (strobe.capture) begin
      baseAddr <= errAddr;
      colCnt   <= '0;
    end else if (strobe.advance) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 physQ <= '0;
    else if (strobe.latchPhys) physQ <= xlRspPhys;
  end

  // Column field substitution, bit by bit
  for (genvar b = 0; b < ADDR_W; b++) begin : g_addrBit
    if (b >= COL_LSB && b <= COL_MSB) begin : g_col
      assign sweptAddr[b] = colCnt[b-COL_LSB];
    end else begin : g_keep
      assign sweptAddr[b] = baseAddr[b];
    end
  end

  assign pfn     = physQ[PA_W-1:PAGE_SHIFT];
  assign lastCol = &colCnt;

endmodule

// File: rtl/rsr_control.sv
module rsr_control
  import rsr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      heteroMode,
  input  logic      xlReqReady,
  input  logic      xlRspValid,
  input  logic      xlRspErr,
  input  logic      pgReqReady,
  input  logic      pgRspValid,
  input  logic      pgRspOnline,
  input  logic      pgRspPoisoned,
  input  logic      retReady,
  input  logic      lastCol,
  output dpStrobe_t strobe,
  output logic      xlReqValid,
  output logic      pgReqValid,
  output logic      retValid,
  output logic      busy,
  output logic      donePulse
);

  seqState_t state, nextState;
  logic      finishNow;

  always_comb begin
    nextState = state;
    strobe    = '0;
    finishNow = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          if (heteroMode) begin
            strobe.capture = 1'b1;
            nextState      = S_XLATE_REQ;
          end else begin
            finishNow = 1'b1;
          end
        end
      end
      S_XLATE_REQ:  if (xlReqReady) nextState = S_XLATE_WAIT;
      S_XLATE_WAIT: begin
        if (xlRspValid) begin
          if (xlRspErr) begin
            nextState = S_NEXT;
          end else begin
            strobe.latchPhys = 1'b1;
            nextState        = S_PAGE_REQ;
          end
        end
      end
      S_PAGE_REQ:   if (pgReqReady) nextState = S_PAGE_WAIT;
      S_PAGE_WAIT: begin
        if (pgRspValid) begin
          if (!pgRspOnline || pgRspPoisoned) nextState = S_NEXT;
          else                               nextState = S_RETIRE;
        end
      end
      S_RETIRE:     if (retReady) nextState = S_NEXT;
      S_NEXT: begin
        if (lastCol) begin
          finishNow = 1'b1;
          nextState = S_IDLE;
        end else begin
          strobe.advance = 1'b1;
          nextState      = S_XLATE_REQ;
        end
      end
      default:      nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= finishNow;
    end
  end

  assign xlReqValid = (state == S_XLATE_REQ);
  assign pgReqValid = (state == S_PAGE_REQ);
  assign retValid   = (state == S_RETIRE);
  assign busy       = (state != S_IDLE);

endmodule

// File: rtl/row_sweep_retire.sv
module row_sweep_retire
  import rsr_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int COL_LSB    = 1,
  parameter int COL_W      = 5,
  parameter int PA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic [ADDR_W-1:0]          errAddr,
  input  logic                       heteroMode,
  output logic                       xlReqValid,
  input  logic                       xlReqReady,
  output logic [ADDR_W-1:0]          xlReqAddr,
  input  logic                       xlRspValid,
  input  logic                       xlRspErr,
  input  logic [PA_W-1:0]            xlRspPhys,
  output logic                       pgReqValid,
  input  logic                       pgReqReady,
  output logic [PA_W-PAGE_SHIFT-1:0] pgReqPfn,
  input  logic                       pgRspValid,
  input  logic                       pgRspOnline,
  input  logic                       pgRspPoisoned,
  output logic                       retValid,
  input  logic                       retReady,
  output logic [PA_W-PAGE_SHIFT-1:0] retPfn,
  output logic                       busy,
  output logic                       donePulse
);

  dpStrobe_t                  strobe;
  logic                       lastCol;
  logic [PA_W-PAGE_SHIFT-1:0] pfn;

  rsr_control i_control (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .heteroMode    (heteroMode),
    .xlReqReady    (xlReqReady),
    .xlRspValid    (xlRspValid),
    .xlRspErr      (xlRspErr),
    .pgReqReady    (pgReqReady),
    .pgRspValid    (pgRspValid),
    .pgRspOnline   (pgRspOnline),
    .pgRspPoisoned (pgRspPoisoned),
    .retReady      (retReady),
    .lastCol       (lastCol),
    .strobe        (strobe),
    .xlReqValid    (xlReqValid),
    .pgReqValid    (pgReqValid),
    .retValid      (retValid),
    .busy          (busy),
    .donePulse     (donePulse)
  );

  rsr_datapath #(
    .ADDR_W     (ADDR_W),
    .COL_LSB    (COL_LSB),
    .COL_W      (COL_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .errAddr   (errAddr),
    .xlRspPhys (xlRspPhys),
    .sweptAddr (xlReqAddr),
    .pfn       (pfn),
    .lastCol   (lastCol)
  );

  assign pgReqPfn = pfn;
  assign retPfn   = pfn;

endmodule

// File: rtl/rsr_checker.sv
module rsr_checker #(
  parameter int ADDR_W     = 28,
  parameter int COL_LSB    = 1,
  parameter int COL_W      = 5,
  parameter int PA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       startReq,
  input logic                       heteroMode,
  input logic                       xlReqValid,
  input logic                       xlReqReady,
  input logic [ADDR_W-1:0]          xlReqAddr,
  input logic                       pgReqValid,
  input logic                       pgReqReady,
  input logic [PA_W-PAGE_SHIFT-1:0] pgReqPfn,
  input logic                       retValid,
  input logic                       retReady,
  input logic [PA_W-PAGE_SHIFT-1:0] retPfn,
  input logic                       busy,
  input logic                       donePulse
);

  localparam logic [ADDR_W-1:0] COL_MASK  = ((ADDR_W'(1) << COL_W) - 1'b1) << COL_LSB;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~COL_MASK;

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && !heteroMode) |=> (donePulse && !busy && !xlReqValid));

  p_pg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pgReqValid && !pgReqReady) |=> (pgReqValid && $stable(pgReqPfn)));

  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !retReady) |=> (retValid && $stable(retPfn)));

  p_xl_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid && !xlReqReady) |=> (xlReqValid && $stable(xlReqAddr)));

  p_one_active_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xlReqValid, pgReqValid, retValid}));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  p_base_kept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ((xlReqAddr & KEEP_MASK) == ($past(xlReqAddr) & KEEP_MASK)));

endmodule

bind row_sweep_retire rsr_checker #(
  .ADDR_W     (ADDR_W),
  .COL_LSB    (COL_LSB),
  .COL_W      (COL_W),
  .PA_W       (PA_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) i_rsr_checker (.*);

// File: tb/test_row_sweep_retire.sv
`timescale 1ns/1ps
module test_row_sweep_retire;

  localparam int ADDR_W = 28;
  localparam int PA_W   = 48;
  localparam int PFN_W  = 36;

  logic              clk = 1'b0;
  logic              rstN;
  logic              startReq;
  logic [ADDR_W-1:0] errAddr;
  logic              heteroMode;
  logic              xlReqValid, xlReqReady;
  logic [ADDR_W-1:0] xlReqAddr;
  logic              xlRspValid, xlRspErr;
  logic [PA_W-1:0]   xlRspPhys;
  logic              pgReqValid, pgReqReady;
  logic [PFN_W-1:0]  pgReqPfn;
  logic              pgRspValid, pgRspOnline, pgRspPoisoned;
  logic              retValid, retReady;
  logic [PFN_W-1:0]  retPfn;
  logic              busy, donePulse;

  always #2 clk = ~clk;

  row_sweep_retire i_row_sweep_retire (.*);

  int checkCount = 0;
  int failCount  = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [31:0] errM, offM, poisM;
  logic [ADDR_W-1:0] xlExpQ[$];
  logic [PFN_W-1:0]  retExpQ[$];
  logic [PFN_W-1:0]  lastPfn;
  logic              lastErr;
  logic [4:0]        lastCol;
  logic              pgSeen;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!cond) begin
      failCount++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int pickDelay();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[1:0]);
  endfunction

  function automatic logic [PA_W-1:0] modelPhys(input logic [ADDR_W-1:0] a);
    return ((PA_W'(a) + 48'h1000) << 12) | 48'h5a5;
  endfunction

  function automatic logic [PFN_W-1:0] modelPfn(input logic [ADDR_W-1:0] a);
    return PFN_W'(a) + 36'h1000;
  endfunction

  // Translator responder and translation-request monitor
  initial begin
    xlReqReady = 0; xlRspValid = 0; xlRspErr = 0; xlRspPhys = '0;
    forever begin
      @(negedge clk);
      if (rstN && xlReqValid) begin
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] e;
        int st;
        int lat;
        a  = xlReqAddr;
        st = pickDelay();
        for (int k = 0; k < st; k++) begin
          @(negedge clk);
          check(xlReqValid && xlReqAddr == a, "R9", "xl request held", 64'(xlReqAddr), 64'(a));
        end
        xlReqReady = 1;
        if (xlExpQ.size() > 0) begin
          e = xlExpQ.pop_front();
          check(a == e, "R3", "translation address", 64'(a), 64'(e));
        end else begin
          check(1'b0, "R3", "unexpected translation request", 64'(a), 64'(0));
        end
        lastCol = a[5:1];
        lastErr = errM[a[5:1]];
        lastPfn = modelPfn(a);
        @(negedge clk);
        xlReqReady = 0;
        lat = pickDelay();
        for (int k = 0; k < lat; k++) @(negedge clk);
        xlRspValid = 1;
        xlRspErr   = lastErr;
        xlRspPhys  = modelPhys(a);
        @(negedge clk);
        xlRspValid = 0;
        xlRspErr   = 0;
      end
    end
  end

  // Page store responder
  initial begin
    pgReqReady = 0; pgRspValid = 0; pgRspOnline = 0; pgRspPoisoned = 0;
    forever begin
      @(negedge clk);
      if (rstN && pgReqValid) begin
        int st;
        st = pickDelay();
        for (int k = 0; k < st; k++) @(negedge clk);
        check(!lastErr, "R4", "page request after translation error", 64'(lastCol), 64'(0));
        check(pgReqPfn == lastPfn, "R5", "page request pfn", 64'(pgReqPfn), 64'(lastPfn));
        pgReqReady = 1;
        @(negedge clk);
        pgReqReady = 0;
        for (int k = 0; k < pickDelay(); k++) @(negedge clk);
        pgRspValid    = 1;
        pgRspOnline   = !offM[lastCol];
        pgRspPoisoned = poisM[lastCol];
        @(negedge clk);
        pgRspValid = 0; pgRspOnline = 0; pgRspPoisoned = 0;
      end
    end
  end

  // Retire monitor (scoreboard sink)
  initial begin
    retReady = 0;
    forever begin
      @(negedge clk);
      if (rstN && retValid) begin
        logic [PFN_W-1:0] p;
        logic [PFN_W-1:0] e;
        int st;
        p  = retPfn;
        st = pickDelay();
        for (int k = 0; k < st; k++) begin
          @(negedge clk);
          check(retValid && retPfn == p, "R8", "retire held until ready", 64'(retPfn), 64'(p));
        end
        retReady = 1;
        if (retExpQ.size() > 0) begin
          e = retExpQ.pop_front();
          check(p == e, "R8", "retire pfn", 64'(p), 64'(e));
        end else begin
          check(1'b0, "R6/R7", "unexpected retire", 64'(p), 64'(0));
        end
        @(negedge clk);
        retReady = 0;
      end
    end
  end

  // Driver: queue expected items, start the sweep, wait for completion
  task automatic runSweep(input logic [ADDR_W-1:0] a, input logic [31:0] eM,
                          input logic [31:0] oM, input logic [31:0] pM, input bit disturb);
    bit seen;
    errM = eM; offM = oM; poisM = pM;
    for (int c = 0; c < 32; c++) begin
      logic [ADDR_W-1:0] v;
      v = a;
      v[5:1] = 5'(c);
      xlExpQ.push_back(v);
      if (!eM[c] && !oM[c] && !pM[c]) retExpQ.push_back(modelPfn(v));
    end
    @(negedge clk);
    errAddr = a; heteroMode = 1; startReq = 1;
    @(negedge clk);
    startReq = 0;
    if (disturb) begin
      repeat (40) @(negedge clk);
      errAddr = ~a; startReq = 1;      // R11: must be ignored
      @(negedge clk);
      startReq = 0;
    end
    seen = 0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      @(negedge clk);
      if (donePulse) seen = 1;
    end
    check(seen, "R10", "done pulse seen", 64'(seen), 64'(1));
    check(!busy, "R10", "busy low with done", 64'(busy), 64'(0));
    check(xlExpQ.size() == 0, "R3", "all 32 columns translated", 64'(xlExpQ.size()), 64'(0));
    check(retExpQ.size() == 0, "R8", "all retires issued", 64'(retExpQ.size()), 64'(0));
    @(negedge clk);
    check(!donePulse, "R10", "done is a single pulse", 64'(donePulse), 64'(0));
    xlExpQ.delete();
    retExpQ.delete();
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    rstN = 0; startReq = 0; errAddr = '0; heteroMode = 0;
    errM = '0; offM = '0; poisM = '0;
    lastPfn = '0; lastErr = 0; lastCol = '0; pgSeen = 0;
    repeat (4) @(negedge clk);
    check(!xlReqValid && !pgReqValid && !retValid, "R1", "request valids low in reset",
          64'({xlReqValid, pgReqValid, retValid}), 64'(0));
    rstN = 1;
    @(negedge clk);
    check(!busy && !donePulse, "R1", "busy/done low after reset", 64'({busy, donePulse}), 64'(0));

    // R2: bypass when the fabric mode is not heterogeneous
    errAddr = 28'h123_4567; heteroMode = 0; startReq = 1;
    @(negedge clk);
    startReq = 0;
    check(donePulse, "R2", "immediate done", 64'(donePulse), 64'(1));
    check(!busy && !xlReqValid, "R2", "no sweep started", 64'({busy, xlReqValid}), 64'(0));
    repeat (5) begin
      @(negedge clk);
      check(!xlReqValid && !pgReqValid && !retValid && !busy, "R2", "stays quiet",
            64'({xlReqValid, pgReqValid, retValid, busy}), 64'(0));
    end

    // Mixed filter outcomes: R4, R6, R7 (column 31 errors)
    runSweep(28'hABC_DEF1, 32'h8000_0081, 32'h0000_0410, 32'h0102_0000, 0);
    // Every column survives
    runSweep(28'h000_0000, 32'h0, 32'h0, 32'h0, 0);
    // Every translation fails: R4
    runSweep(28'hFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 0);
    // Offline and poisoned overlap: R6, R7
    runSweep(28'h5A5_A5A5, 32'h0, 32'hF0F0_0000, 32'h0F0F_00FF, 0);
    // Start pulse and address change while busy: R11
    runSweep(28'h765_4321, 32'h0000_1000, 32'h0002_0000, 32'h0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule